// File: doc/BRIEF.md
# Signed Product Multiplier by Magnitude and Conditional Negation

This block multiplies two 4-bit two's-complement operands and returns their 8-bit two's-complement product, entirely in combinational logic. It does not handle signs inside the multiplier array. It first turns each operand into its unsigned magnitude, then passes the two magnitudes through a plain unsigned array multiplier. It then negates the unsigned product whenever the operands carry opposite signs.

Every negation is done by one adder/subtracter design that is steered by a mode bit. Mode 0 adds and mode 1 subtracts, and a negation is formed as zero minus the value. A small control module reads the two sign bits and drives the mode strobes. The datapath holds the magnitude units, the array core and the product negation unit. The magnitude of the most negative operand, binary 1000, is taken as the unsigned value 8, which the 4-bit core represents without loss.

Top module: `sm_product_mult`

## Requirements
- R1: For every one of the 256 operand pairs, `product` equals the signed product of `opA` and `opB` as an 8-bit two's-complement value, where bit 3 of each operand is its sign bit.
- R2: When both sign bits (bit 3) are 0, `product` equals the unsigned product of the operands and its bit 7 is 0.
- R3: When both sign bits are 1, `product` equals the product of the two magnitudes and its bit 7 is 0.
- R4: When the sign bits differ and neither operand is zero, bit 7 of `product` is 1.
- R5: The operand 4'b1000 is treated as magnitude 8: 4'b1000 times 4'b1000 gives 8'h40 (+64), and 4'b1000 times 4'b0111 (in either order) gives 8'hC8 (-56).
- R6: When either operand is zero, `product` is 8'h00 whatever the sign of the other operand. For example, 0 times 4'b1101 (-3) gives 0.
- R7: `product` depends only on the present operand values and holds no state, so it follows a change of the operands without any clock edge.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 4 | First operand, two's complement, bit 3 is the sign |
| opB | input | 4 | Second operand, two's complement, bit 3 is the sign |
| product | output | 8 | Signed product, two's complement |

## Verification
Every time the operands change, the bound checker compares the sign of the result with the two operand signs (R2, R3, R4). It also checks that a zero operand gives a zero result (R6), checks the two corner products of the value 1000 (R5), and compares the result with a behavioural signed multiply (R1). Only the bench can show that the block is complete over all 256 pairs and that it tracks operand changes with no clock (R7). It walks every pair and also changes the operands between clock edges.

// File: rtl/smm_pkg.sv
package smm_pkg;

  // Operation selected on an adder/subtracter: 0 adds, 1 subtracts.
  typedef enum logic {
    MODE_ADD = 1'b0,
    MODE_SUB = 1'b1
  } addsub_mode_e;

  // Strobes from the sign control to the datapath.
  typedef struct packed {
    addsub_mode_e negA;
    addsub_mode_e negB;
    addsub_mode_e negProd;
  } smm_strobe_t;

endpackage

// File: rtl/smm_addsub.sv
// Ripple-carry adder/subtracter: sum = x + y (mode add) or x - y (mode sub).
module smm_addsub
  import smm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]  x,
  input  logic [W-1:0]  y,
  input  addsub_mode_e  mode,
  output logic [W-1:0]  sum
);

  logic         subBit;
  logic [W-1:0] yEff;
  logic [W-1:0] carry;

  assign subBit   = (mode == MODE_SUB);
  assign yEff     = y ^ {W{subBit}};
  assign carry[0] = subBit;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i] = x[i] ^ yEff[i] ^ carry[i];
    if (i < W - 1) begin : g_carry
      assign carry[i+1] = (x[i] & yEff[i]) | (carry[i] & (x[i] ^ yEff[i]));
    end
  end

endmodule

// File: rtl/smm_array_core.sv
// Unsigned array multiplier: AND-gated partial products summed row by row.
module smm_array_core
  import smm_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic [OP_W-1:0]   aMag,
  input  logic [OP_W-1:0]   bMag,
  output logic [2*OP_W-1:0] uProd
);

  localparam int PROD_W = 2 * OP_W;

  logic [OP_W-1:0][PROD_W-1:0] partial;
  logic [OP_W-1:0][PROD_W-1:0] accum;

  for (genvar i = 0; i < OP_W; i++) begin : g_row
    assign partial[i] = {{OP_W{1'b0}}, aMag & {OP_W{bMag[i]}}} << i;
    if (i == 0) begin : g_first
      assign accum[i] = partial[i];
    end else begin : g_add
      smm_addsub #(.W(PROD_W)) rowAdd_i (
        .x    (accum[i-1]),
        .y    (partial[i]),
        .mode (MODE_ADD),
        .sum  (accum[i])
      );
    end
  end

  assign uProd = accum[OP_W-1];

endmodule

// File: rtl/smm_ctrl.sv
// Sign control: turns the operand sign bits into adder/subtracter strobes.
module smm_ctrl
  import smm_pkg::*;
(
  input  logic        signA,
  input  logic        signB,
  output smm_strobe_t strobe
);

  always_comb begin
    strobe.negA    = signA ? MODE_SUB : MODE_ADD;
    strobe.negB    = signB ? MODE_SUB : MODE_ADD;
    strobe.negProd = (signA ^ signB) ? MODE_SUB : MODE_ADD;
  end

endmodule

// File: rtl/smm_datapath.sv
// Magnitude conversion, unsigned core and conditional product negation.
module smm_datapath
  import smm_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  smm_strobe_t       strobe,
  output logic [2*OP_W-1:0] product
);

  localparam int PROD_W = 2 * OP_W;

  logic [OP_W-1:0]   aMag;
  logic [OP_W-1:0]   bMag;
  logic [PROD_W-1:0] uProd;

  smm_addsub #(.W(OP_W)) magA_i (
    .x    ({OP_W{1'b0}}),
    .y    (opA),
    .mode (strobe.negA),
    .sum  (aMag)
  );

  smm_addsub #(.W(OP_W)) magB_i (
    .x    ({OP_W{1'b0}}),
    .y    (opB),
    .mode (strobe.negB),
    .sum  (bMag)
  );

  smm_array_core #(.OP_W(OP_W)) core_i (
    .aMag  (aMag),
    .bMag  (bMag),
    .uProd (uProd)
  );

  smm_addsub #(.W(PROD_W)) negProd_i (
    .x    ({PROD_W{1'b0}}),
    .y    (uProd),
    .mode (strobe.negProd),
    .sum  (product)
  );

endmodule

// File: rtl/sm_product_mult.sv
module sm_product_mult
  import smm_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [2*OP_W-1:0] product
);

  smm_strobe_t strobe;

  smm_ctrl ctrl_i (
    .signA  (opA[OP_W-1]),
    .signB  (opB[OP_W-1]),
    .strobe (strobe)
  );

  smm_datapath #(.OP_W(OP_W)) dp_i (
    .opA     (opA),
    .opB     (opB),
    .strobe  (strobe),
    .product (product)
  );

endmodule

// File: rtl/sm_product_mult_chk.sv
module sm_product_mult_chk #(
  parameter int OP_W = 4
) (
  input logic [OP_W-1:0]   opA,
  input logic [OP_W-1:0]   opB,
  input logic [2*OP_W-1:0] product
);

  localparam int PROD_W = 2 * OP_W;
  localparam logic [OP_W-1:0] MOST_NEG = {1'b1, {(OP_W-1){1'b0}}};
  localparam logic [OP_W-1:0] MOST_POS = {1'b0, {(OP_W-1){1'b1}}};

  logic sA, sB, zeroIn;
  logic [PROD_W-1:0] refProd;

  always_comb begin
    sA      = opA[OP_W-1];
    sB      = opB[OP_W-1];
    zeroIn  = (opA == '0) || (opB == '0);
    refProd = PROD_W'($signed({{OP_W{opA[OP_W-1]}}, opA}) * $signed({{OP_W{opB[OP_W-1]}}, opB}));
  end

  always_comb begin
    if (!$isunknown({opA, opB, product})) begin
      // R1
      signed_ref_chk: assert (product == refProd);
      // R2
      pos_pos_sign_chk: assert (!(!sA && !sB) || !product[PROD_W-1]);
      // R3
      neg_neg_sign_chk: assert (!(sA && sB) || !product[PROD_W-1]);
      // R4
      mixed_sign_chk: assert (!((sA ^ sB) && !zeroIn) || product[PROD_W-1]);
      // R5
      most_neg_sq_chk: assert (!(opA == MOST_NEG && opB == MOST_NEG) || product == PROD_W'(1) << (2*OP_W-2));
      // R5
      most_neg_pos_chk: assert (!(opA == MOST_NEG && opB == MOST_POS) || product[PROD_W-1]);
      // R6
      zero_in_chk: assert (!zeroIn || product == '0);
    end
  end

endmodule

bind sm_product_mult sm_product_mult_chk #(.OP_W(OP_W)) chk_i (
  .opA     (opA),
  .opB     (opB),
  .product (product)
);

// File: tb/sm_product_mult_tb_top.sv
module sm_product_mult_tb_top;

  localparam int NVEC = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  // {opA, opB, expected product}
  localparam logic [15:0] VEC [NVEC] = '{
    {4'h8, 4'h8, 8'h40},
    {4'h8, 4'h7, 8'hC8},
    {4'h7, 4'h8, 8'hC8},
    {4'h0, 4'hD, 8'h00},
    {4'hD, 4'h0, 8'h00},
    {4'h8, 4'h0, 8'h00},
    {4'h7, 4'h7, 8'h31},
    {4'hF, 4'hF, 8'h01},
    {4'hF, 4'h1, 8'hFF},
    {4'h8, 4'h1, 8'hF8}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] opA = 4'h0;
  logic [3:0] opB = 4'h0;
  logic [7:0] product;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sm_product_mult dut_i (
    .opA     (opA),
    .opB     (opB),
    .product (product)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", tag, opA, opB, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Start state: zero operands give zero (R6)
    check("R6 start", product, 8'h00);

    // Corner table (R5, R6, R3, R4)
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      opA = VEC[i][15:12];
      opB = VEC[i][11:8];
      #5;
      check("R5 R6 corner table", product, VEC[i][7:0]);
    end

    // Exhaustive sweep against a behavioural signed multiply (R1)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        int sa, sb;
        logic [7:0] exp;
        @(negedge clk);
        opA = 4'(a);
        opB = 4'(b);
        sa = (a >= 8) ? a - 16 : a;
        sb = (b >= 8) ? b - 16 : b;
        exp = 8'(sa * sb);
        #5;
        check("R1", product, exp);
        if (sa >= 0 && sb >= 0)
          check("R2", {7'b0, product[7]}, 8'h00);
        else if (sa < 0 && sb < 0)
          check("R3", {7'b0, product[7]}, 8'h00);
        else if (sa != 0 && sb != 0)
          check("R4", {7'b0, product[7]}, 8'h01);
        else
          check("R6", product, 8'h00);
      end
    end

    // R7: operands change between clock edges, result follows
    @(negedge clk);
    opA = 4'h3;
    opB = 4'h2;
    #1;
    check("R7 first", product, 8'h06);
    opB = 4'hE;
    #1;
    check("R7 second", product, 8'hFA);

    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule